// File: doc/BRIEF.md
# Power Save Control Register

An 8-bit control register that puts the controller into a low-power state and takes it out again. The same register also decides which interrupt sources may wake the controller. Software changes the register through a byte-wide write or a single-bit write. A write lands only when it comes straight after an unlock strobe, which stands for a write to the protection command register. A write that arrives without that unlock is dropped, and an error pulse reports it.

Three wake requests come in: the watchdog non-maskable request, the external non-maskable request, and the dedicated maskable interrupt request. Each request has its own mask bit in the register. While the power-save bit is set, any request whose mask bit is clear raises a wake event. On the next clock edge, hardware clears the power-save bit.

Register layout: bit 6 masks the watchdog request, bit 5 masks the external request, bit 4 masks the maskable request, and bit 1 is the power-save bit. Bits 7, 3, 2 and 0 are reserved. A mask bit of 1 blocks its source and a mask bit of 0 lets it wake the controller.

Top module: `psc_ctrl`

## Requirements
- R1: After reset, rd_data_o reads 0x00, psave_o is 0 and wake_o is 0.
- R2: Bits 7, 3, 2 and 0 always read 0. Byte writes and single-bit writes to these bits leave the register unchanged.
- R3: A byte write (wr_en_i=1, wr_bit_i=0) accepted on a clock edge loads bits 6, 5, 4 and 1 from wr_data_i. psave_o equals bit 1 of the register.
- R4: A single-bit write (wr_en_i=1, wr_bit_i=1) sets bit wr_sel_i to wr_val_i and leaves every other bit unchanged.
- R5: A write is accepted only if unlock_i was 1 on the cycle just before it. A write without that unlock leaves the register unchanged and sets prot_err_o to 1 for the cycle after it.
- R6: An unlock arms exactly one following cycle. If an idle cycle comes between the unlock and the write, the write is rejected as in R5.
- R7: wake_o is combinational. It is 1 when bit 1 is set and at least one of these holds: wdt_req_i with bit 6 clear, ext_req_i with bit 5 clear, or irq_req_i with bit 4 clear.
- R8: While bit 1 is 0, wake_o stays 0 whatever the requests are.
- R9: On the clock edge where wake_o is 1, hardware clears bit 1. The mask bits are not affected.
- R10: If an accepted write and a wake occur in the same cycle, bit 1 ends up 0. The write still updates bits 6, 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| unlock_i | input | 1 | Protection command strobe; arms the next cycle for a write |
| wr_en_i | input | 1 | Register write request |
| wr_bit_i | input | 1 | 1 selects a single-bit write, 0 selects a byte write |
| wr_sel_i | input | 3 | Bit index for a single-bit write |
| wr_val_i | input | 1 | Bit value for a single-bit write |
| wr_data_i | input | 8 | Data for a byte write |
| wdt_req_i | input | 1 | Watchdog non-maskable wake request |
| ext_req_i | input | 1 | External non-maskable wake request |
| irq_req_i | input | 1 | Dedicated maskable wake request |
| rd_data_o | output | 8 | Register contents |
| psave_o | output | 1 | Power save active (bit 1) |
| wake_o | output | 1 | Wake event from an unmasked request |
| prot_err_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
The bench builds the block with its package defaults: an 8-bit register, a 3-bit bit selector and three wake sources. These settings reach every reserved bit index through single-bit writes and every mask-to-source pairing. They also reach the cycle where an accepted write collides with a wake. Rejected writes are tested both without any unlock and with an idle cycle between the unlock and the write.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int REG_W   = 8;
  localparam int SEL_W   = $clog2(REG_W);
  localparam int NUM_SRC = 3;

  localparam int POS_STP     = 1;
  localparam int POS_MSK_IRQ = 4;
  localparam int POS_MSK_EXT = 5;
  localparam int POS_MSK_WDT = 6;

  // writable field map; all other bits are reserved
  localparam logic [REG_W-1:0] WR_MASK =
    REG_W'((1 << POS_STP) | (1 << POS_MSK_IRQ) | (1 << POS_MSK_EXT) | (1 << POS_MSK_WDT));

  typedef enum logic [1:0] {
    SRC_WDT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_IRQ = 2'd2
  } wake_src_e;

  function automatic int mask_pos(input int src);
    case (src)
      0:       return POS_MSK_WDT;
      1:       return POS_MSK_EXT;
      default: return POS_MSK_IRQ;
    endcase
  endfunction
endpackage

// File: rtl/psc_unlock.sv
module psc_unlock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic unlock_i,
  input  logic wr_en_i,
  output logic wr_ok_o,
  output logic err_o
);
  logic armed_q;
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      armed_q <= unlock_i;
      err_q   <= wr_en_i & ~armed_q;
    end
  end

  assign wr_ok_o = wr_en_i & armed_q;
  assign err_o   = err_q;

  p_arm_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_o |-> $past(unlock_i));
  p_err_on_reject_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_ok_o) |=> err_o);
  p_no_err_on_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok_o || !wr_en_i) |=> !err_o);
endmodule

// File: rtl/psc_wake.sv
module psc_wake #(
  parameter int N = psc_pkg::NUM_SRC
) (
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] mask_i,
  output logic         wake_o
);
  logic [N-1:0] hit;

  for (genvar s = 0; s < N; s++) begin : g_src
    assign hit[s] = req_i[s] & ~mask_i[s];
  end

  assign wake_o = en_i & (|hit);

  always_comb begin
    if (!en_i) p_idle_no_wake_r8: assert (!wake_o);
  end
endmodule

// File: rtl/psc_reg.sv
module psc_reg
  import psc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ok_i,
  input  logic             wr_bit_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic             wr_val_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             clr_stp_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] q;
  logic [REG_W-1:0] wdata;
  logic [REG_W-1:0] nxt;

  always_comb begin
    wdata = wr_data_i;
    if (wr_bit_i) begin
      wdata = q;
      wdata[wr_sel_i] = wr_val_i;
    end
    nxt = q;
    if (wr_ok_i) nxt = (q & ~WR_MASK) | (wdata & WR_MASK);
    if (clr_stp_i) nxt[POS_STP] = 1'b0;  // wake wins over write
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign q_o = q;

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q & ~WR_MASK) == '0);
  p_hold_unwritten_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ok_i && !clr_stp_i) |=> $stable(q));
  p_stp_cleared_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_stp_i |=> !q[POS_STP]);
endmodule

// File: rtl/psc_ctrl.sv
module psc_ctrl
  import psc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             unlock_i,
  input  logic             wr_en_i,
  input  logic             wr_bit_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic             wr_val_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             wdt_req_i,
  input  logic             ext_req_i,
  input  logic             irq_req_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             psave_o,
  output logic             wake_o,
  output logic             prot_err_o
);
  logic             wr_ok;
  logic             wake;
  logic [REG_W-1:0] q;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] msk;

  assign req[SRC_WDT] = wdt_req_i;
  assign req[SRC_EXT] = ext_req_i;
  assign req[SRC_IRQ] = irq_req_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_msk
    assign msk[s] = q[mask_pos(s)];
  end

  psc_unlock u_unlock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .unlock_i(unlock_i),
    .wr_en_i (wr_en_i),
    .wr_ok_o (wr_ok),
    .err_o   (prot_err_o)
  );

  psc_wake #(.N(NUM_SRC)) u_wake (
    .en_i  (q[POS_STP]),
    .req_i (req),
    .mask_i(msk),
    .wake_o(wake)
  );

  psc_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ok_i  (wr_ok),
    .wr_bit_i (wr_bit_i),
    .wr_sel_i (wr_sel_i),
    .wr_val_i (wr_val_i),
    .wr_data_i(wr_data_i),
    .clr_stp_i(wake),
    .q_o      (q)
  );

  assign rd_data_o = q;
  assign psave_o   = q[POS_STP];
  assign wake_o    = wake;

  p_wake_beats_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && wr_ok) |=> !psave_o);
  p_masks_kept_on_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !wr_ok) |=> $stable(rd_data_o[POS_MSK_WDT:POS_MSK_IRQ]));
endmodule

// File: tb/psc_ctrl_tb_top.sv
module psc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 5000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       unlock_i = 0, wr_en_i = 0, wr_bit_i = 0, wr_val_i = 0;
  logic [2:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       wdt_req_i = 0, ext_req_i = 0, irq_req_i = 0;
  logic [7:0] rd_data_o;
  logic       psave_o, wake_o, prot_err_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  // bench-side model state
  logic [7:0] m_reg = '0;
  logic       m_arm = 1'b0;

  logic [8:0] q_val[$];
  string      q_tag[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  psc_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .unlock_i(unlock_i), .wr_en_i(wr_en_i),
    .wr_bit_i(wr_bit_i), .wr_sel_i(wr_sel_i), .wr_val_i(wr_val_i),
    .wr_data_i(wr_data_i), .wdt_req_i(wdt_req_i), .ext_req_i(ext_req_i),
    .irq_req_i(irq_req_i), .rd_data_o(rd_data_o), .psave_o(psave_o),
    .wake_o(wake_o), .prot_err_o(prot_err_o)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare post-edge state against the queued expectation
  always @(posedge clk_i) begin
    #1;
    if (q_val.size() > 0) begin
      logic [8:0] e;
      string t;
      e = q_val.pop_front();
      t = q_tag.pop_front();
      chk({6'd0, psave_o, prot_err_o, rd_data_o}, {6'd0, e[1], e[8], e[7:0]}, t);
    end
  end

  // driver: one cycle of stimulus, expected next state pushed to the scoreboard
  task automatic step(input logic u, input logic we, input logic wb, input logic [2:0] sel,
                      input logic val, input logic [7:0] dat,
                      input logic wdt, input logic ext, input logic irq, input string tag);
    logic [7:0] wd, nx;
    logic ew, ok, er;
    @(negedge clk_i);
    unlock_i = u; wr_en_i = we; wr_bit_i = wb; wr_sel_i = sel; wr_val_i = val;
    wr_data_i = dat; wdt_req_i = wdt; ext_req_i = ext; irq_req_i = irq;
    #1;
    ew = m_reg[1] & ((wdt & ~m_reg[6]) | (ext & ~m_reg[5]) | (irq & ~m_reg[4]));
    chk({15'd0, wake_o}, {15'd0, ew}, {tag, " wake"});
    ok = we & m_arm;
    er = we & ~m_arm;
    wd = dat;
    if (wb) begin
      wd = m_reg;
      wd[sel] = val;
    end
    nx = ok ? (wd & 8'h72) : m_reg;
    if (ew) nx[1] = 1'b0;
    m_reg = nx;
    m_arm = u;
    q_val.push_back({er, nx});
    q_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 3'd0, 0, 8'h00, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    // R1: reset state
    chk({6'd0, psave_o, wake_o, rd_data_o}, 16'h0000, "R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({6'd0, psave_o, wake_o, rd_data_o}, 16'h0000, "R1 after release");

    // R5: write without unlock
    step(0, 1, 0, 3'd0, 0, 8'h72, 0, 0, 0, "R5 no unlock");
    idle("R5 err cleared");
    // R6: unlock, gap, write
    step(1, 0, 0, 3'd0, 0, 8'h00, 0, 0, 0, "R6 unlock");
    idle("R6 gap");
    step(0, 1, 0, 3'd0, 0, 8'h70, 0, 0, 0, "R6 late write");
    // R3: accepted byte write of masks
    step(1, 0, 0, 3'd0, 0, 8'h00, 0, 0, 0, "R3 unlock");
    step(0, 1, 0, 3'd0, 0, 8'h70, 0, 0, 0, "R3 byte write");
    // R2: reserved bits ignored in byte write, enters power save
    step(1, 0, 0, 3'd0, 0, 8'h00, 0, 0, 0, "R2 unlock");
    step(0, 1, 0, 3'd0, 0, 8'hFF, 0, 0, 0, "R2 byte write ff");
    // R7: all masked, no wake
    step(0, 0, 0, 3'd0, 0, 8'h00, 1, 1, 1, "R7 all masked");
    // R4: single-bit clear of watchdog mask
    step(1, 0, 0, 3'd0, 0, 8'h00, 0, 0, 0, "R4 unlock");
    step(0, 1, 1, 3'd6, 0, 8'hFF, 0, 0, 0, "R4 bit6 clear");
    // R2: single-bit writes to reserved bits
    for (int b = 0; b < 8; b++) begin
      if (b == 0 || b == 2 || b == 3 || b == 7) begin
        step(1, 0, 0, 3'd0, 0, 8'h00, 0, 0, 0, "R2 unlock");
        step(0, 1, 1, 3'(b), 1, 8'h00, 0, 0, 0, "R2 rsvd bit write");
      end
    end
    // R7/R9: watchdog unmasked wakes, STP clears, masks stay
    step(0, 0, 0, 3'd0, 0, 8'h00, 0, 1, 1, "R7 ext irq masked");
    step(0, 0, 0, 3'd0, 0, 8'h00, 1, 0, 0, "R9 wdt wake");
    // R8: STP clear, no wake
    step(0, 0, 0, 3'd0, 0, 8'h00, 1, 1, 1, "R8 stp low");
    // R4: set STP by bit write, unmask maskable source
    step(1, 0, 0, 3'd0, 0, 8'h00, 0, 0, 0, "R4 unlock");
    step(0, 1, 1, 3'd1, 1, 8'h00, 0, 0, 0, "R4 set stp");
    step(1, 0, 0, 3'd0, 0, 8'h00, 0, 1, 0, "R7 ext masked");
    step(0, 1, 1, 3'd4, 0, 8'h00, 0, 0, 0, "R4 bit4 clear");
    step(0, 0, 0, 3'd0, 0, 8'h00, 0, 0, 1, "R7 irq wake");
    // R3: enable ext source, set STP
    step(1, 0, 0, 3'd0, 0, 8'h00, 0, 0, 0, "R3 unlock");
    step(0, 1, 0, 3'd0, 0, 8'h52, 0, 0, 0, "R3 write 52");
    step(0, 0, 0, 3'd0, 0, 8'h00, 0, 1, 0, "R7 ext wake");
    // R10: set STP with irq unmasked, then write colliding with wake
    step(1, 0, 0, 3'd0, 0, 8'h00, 0, 0, 0, "R10 unlock");
    step(0, 1, 0, 3'd0, 0, 8'h02, 0, 0, 0, "R10 set stp");
    step(1, 0, 0, 3'd0, 0, 8'h00, 0, 0, 0, "R10 unlock");
    step(0, 1, 0, 3'd0, 0, 8'h62, 0, 0, 1, "R10 collide");
    idle("R10 settle");
    idle("R10 settle");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WDOG_LIMIT && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WDOG_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule